// File: doc/BRIEF.md
# Latched Event Counter Peripheral

This block is a memory-mapped counter peripheral on an 8-bit-data, 16-bit-address processor bus. It keeps free-running 64-bit counts of clock cycles, retired instructions, accepted IRQs and accepted NMIs. It also keeps an elapsed-time count, which can be read either as one nanosecond total or as whole seconds plus a nanosecond remainder. The elapsed time advances by a fixed number of nanoseconds every fixed number of clocks. Both numbers are parameters, as is the length of one second in nanoseconds.

Software takes a coherent picture of all counters by writing any value to a capture register. A selector register then chooses which captured 64-bit value appears in an eight-byte read window. Until the first capture, every captured value reads as zero. Reads never disturb any state. Read data is registered and appears on the clock after the read strobe.

The register window starts at the parameter `BASE` (default $FFC0):

| Offset | Access | Meaning |
|---|---|---|
| 0 | W (reads 0) | capture all counters |
| 1 | R/W | selector |
| 2..9 | R | selected captured value, byte 0 first |

The selector codes are:

| Code | Captured value |
|---|---|
| $00 | cycles |
| $01 | instructions |
| $02 | IRQs |
| $03 | NMIs |
| $80 | elapsed nanoseconds |
| $81 | seconds:remainder |

Top module: `evt_snap_ctr`

## Requirements
- R1: While `rst` is high and on the first clock after it, `bus_rdata` is zero. The selector resets to $00, and all captured values reset to zero.
- R2: Before the first write to offset 0, every value-window byte reads zero under every selector code. Captured values change only on a write to offset 0.
- R3: The selector code picks the captured value as follows: $00 cycles, $01 instructions, $02 IRQs, $03 NMIs, $80 elapsed nanoseconds, $81 split elapsed time. Any other code makes the value window read zero.
- R4: The value window is little-endian: offset 2 returns bits 7:0 of the selected captured value, and offset 2+k returns bits 8k+7:8k, up to offset 9.
- R5: The cycle counter rises by one on every clock after reset. Each event counter rises by one on every clock in which its pulse input is high. All counters wrap modulo 2^64.
- R6: A write to offset 0 copies every counter on the same clock edge. An event pulse or cycle increment on that same edge is not included in the copy.
- R7: The elapsed-nanosecond count rises by `TICK_NS` once every `TICK_CYCLES` clocks, starting from zero at reset.
- R8: In split form, bits 63:32 hold whole seconds and bits 31:0 hold the remainder, which always stays below `SEC_NS`. Seconds times `SEC_NS` plus the remainder equals the elapsed-nanosecond total while the total is below 2^32 seconds.
- R9: Offset 0 reads zero. Offset 1 reads back the last value written to it. No read changes any register.
- R10: `bus_rdata` shows the value addressed on the previous clock when `bus_re` was high on that clock, and zero otherwise. Addresses outside offsets 0..9 read zero.
- R11: Writes to offsets 2..9 and to addresses outside the window change neither the selector nor any captured value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Bus address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one access per clock |
| bus_re | input | 1 | Read strobe |
| ev_instr | input | 1 | Instruction-retired pulse |
| ev_irq | input | 1 | Accepted-IRQ pulse |
| ev_nmi | input | 1 | Accepted-NMI pulse |
| bus_rdata | output | 8 | Registered read data |

## Verification
A live counter that drifts by one shows up as a value-byte mismatch on the first read after the next capture. That read comes no sooner than two clocks after the fault, because the value must first be captured and then read out through a registered port. A wrong selector or a byte-order fault shows up on the clock after the offending read. A split-time carry fault only becomes visible once a second boundary has passed and been captured. For that reason the bench shortens the second to a few dozen ticks and cross-checks the split value against the nanosecond total.

// File: rtl/evs_pkg.sv
package evs_pkg;
  localparam int CW     = 64;
  localparam int N_EVT  = 3;
  localparam int N_SNAP = 6;
  localparam logic [7:0] SEL_CYC   = 8'h00;
  localparam logic [7:0] SEL_INS   = 8'h01;
  localparam logic [7:0] SEL_IRQ   = 8'h02;
  localparam logic [7:0] SEL_NMI   = 8'h03;
  localparam logic [7:0] SEL_NS    = 8'h80;
  localparam logic [7:0] SEL_SPLIT = 8'h81;
  typedef enum logic [2:0] {
    IX_CYC = 3'd0, IX_INS = 3'd1, IX_IRQ = 3'd2,
    IX_NMI = 3'd3, IX_NS = 3'd4, IX_SPLIT = 3'd5
  } snap_ix_e;
endpackage

// File: rtl/evs_event_ctrs.sv
module evs_event_ctrs #(
  parameter int CW    = 64,
  parameter int N_EVT = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      capture,
  input  logic [N_EVT-1:0]          ev,
  output logic [CW-1:0]             snap_cyc,
  output logic [N_EVT-1:0][CW-1:0]  snap_evt
);
  logic [CW-1:0] cyc_q;
  logic [N_EVT-1:0][CW-1:0] evt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q    <= '0;
      snap_cyc <= '0;
    end else begin
      cyc_q <= cyc_q + 1'b1;
      if (capture) snap_cyc <= cyc_q;
    end
  end

  for (genvar g = 0; g < N_EVT; g++) begin : g_evt
    always_ff @(posedge clk) begin
      if (rst) begin
        evt_q[g]    <= '0;
        snap_evt[g] <= '0;
      end else begin
        if (ev[g]) evt_q[g] <= evt_q[g] + 1'b1;
        if (capture) snap_evt[g] <= evt_q[g];
      end
    end
  end

  p_cyc_step_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cyc_q == $past(cyc_q) + 1'b1);
  p_snap_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(snap_cyc) && $stable(snap_evt));
  p_pre_incr_r6: assert property (@(posedge clk) disable iff (rst)
    (capture && ev[0]) |=> evt_q[0] == snap_evt[0] + 1'b1);
endmodule

// File: rtl/evs_time.sv
module evs_time #(
  parameter int CW          = 64,
  parameter int TICK_CYCLES = 4,
  parameter int TICK_NS     = 16,
  parameter int SEC_NS      = 1000000000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture,
  output logic [CW-1:0] snap_ns,
  output logic [CW-1:0] snap_split
);
  localparam int PW = $clog2(TICK_CYCLES + 1);
  localparam int HW = CW / 2;
  localparam logic [PW-1:0] PC_LAST = PW'(TICK_CYCLES - 1);
  localparam logic [HW-1:0] STEP    = HW'(TICK_NS);
  localparam logic [HW-1:0] SEC_LIM = HW'(SEC_NS);

  logic [PW-1:0] pc_q;
  logic [CW-1:0] ns_q;
  logic [HW-1:0] sec_q, sub_q, sub_sum;
  logic          tick;

  assign tick    = (pc_q == PC_LAST);
  assign sub_sum = sub_q + STEP;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q       <= '0;
      ns_q       <= '0;
      sec_q      <= '0;
      sub_q      <= '0;
      snap_ns    <= '0;
      snap_split <= '0;
    end else begin
      if (capture) begin
        snap_ns    <= ns_q;
        snap_split <= {sec_q, sub_q};
      end
      if (tick) begin
        pc_q <= '0;
        ns_q <= ns_q + CW'(TICK_NS);
        if (sub_sum >= SEC_LIM) begin
          sub_q <= sub_sum - SEC_LIM;
          sec_q <= sec_q + 1'b1;
        end else begin
          sub_q <= sub_sum;
        end
      end else begin
        pc_q <= pc_q + 1'b1;
      end
    end
  end

  p_sub_range_r8: assert property (@(posedge clk) disable iff (rst)
    sub_q < SEC_LIM);
  p_sec_carry_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (sec_q == $past(sec_q)) || (sub_q < $past(sub_q)));
  p_ns_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(ns_q));
endmodule

// File: rtl/evs_regs.sv
module evs_regs
  import evs_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [15:0] BASE = 16'hFFC0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [AW-1:0]              addr,
  input  logic [DW-1:0]              wdata,
  input  logic                       we,
  input  logic                       re,
  input  logic [N_SNAP-1:0][CW-1:0]  snaps,
  output logic                       capture,
  output logic [DW-1:0]              rdata
);
  localparam int NBYTE = CW / DW;
  localparam int BW    = $clog2(NBYTE);
  localparam logic [AW-1:0] OFF_CAP = AW'(0);
  localparam logic [AW-1:0] OFF_SEL = AW'(1);
  localparam logic [AW-1:0] OFF_WIN = AW'(2);
  localparam logic [AW-1:0] OFF_END = AW'(2 + NBYTE);

  logic [DW-1:0] sel_q;
  logic [AW-1:0] off;
  logic          in_win, sel_wr;
  logic [BW-1:0] bix;
  logic [CW-1:0] val;
  logic [DW-1:0] rd_nxt;

  assign off     = addr - AW'(BASE);
  assign in_win  = (addr >= AW'(BASE)) && (off < OFF_END);
  assign capture = we && in_win && (off == OFF_CAP);
  assign sel_wr  = we && in_win && (off == OFF_SEL);
  assign bix     = BW'(off - OFF_WIN);

  always_comb begin
    case (sel_q)
      SEL_CYC:   val = snaps[IX_CYC];
      SEL_INS:   val = snaps[IX_INS];
      SEL_IRQ:   val = snaps[IX_IRQ];
      SEL_NMI:   val = snaps[IX_NMI];
      SEL_NS:    val = snaps[IX_NS];
      SEL_SPLIT: val = snaps[IX_SPLIT];
      default:   val = '0;
    endcase
  end

  always_comb begin
    rd_nxt = '0;
    if (in_win) begin
      if (off == OFF_SEL)      rd_nxt = sel_q;
      else if (off >= OFF_WIN) rd_nxt = val[{bix, 3'b000} +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      rdata <= '0;
    end else begin
      if (sel_wr) sel_q <= wdata;
      rdata <= re ? rd_nxt : '0;
    end
  end

  p_idle_zero_r10: assert property (@(posedge clk) disable iff (rst)
    !re |=> rdata == '0);
  p_cap_reads_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (re && addr == AW'(BASE)) |=> rdata == '0);
  p_sel_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !sel_wr |=> $stable(sel_q));
endmodule

// File: rtl/evt_snap_ctr.sv
module evt_snap_ctr
  import evs_pkg::*;
#(
  parameter logic [15:0] BASE = 16'hFFC0,
  parameter int TICK_CYCLES   = 4,
  parameter int TICK_NS       = 16,
  parameter int SEC_NS        = 1000000000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] bus_addr,
  input  logic [7:0]  bus_wdata,
  input  logic        bus_we,
  input  logic        bus_re,
  input  logic        ev_instr,
  input  logic        ev_irq,
  input  logic        ev_nmi,
  output logic [7:0]  bus_rdata
);
  logic                      capture;
  logic [N_SNAP-1:0][CW-1:0] snaps;
  logic [N_EVT-1:0][CW-1:0]  snap_evt;
  logic [CW-1:0]             snap_cyc, snap_ns, snap_split;

  evs_event_ctrs #(.CW(CW), .N_EVT(N_EVT)) i_ctrs (
    .clk(clk), .rst(rst), .capture(capture),
    .ev({ev_nmi, ev_irq, ev_instr}),
    .snap_cyc(snap_cyc), .snap_evt(snap_evt)
  );

  evs_time #(.CW(CW), .TICK_CYCLES(TICK_CYCLES), .TICK_NS(TICK_NS),
             .SEC_NS(SEC_NS)) i_time (
    .clk(clk), .rst(rst), .capture(capture),
    .snap_ns(snap_ns), .snap_split(snap_split)
  );

  assign snaps[IX_CYC]   = snap_cyc;
  assign snaps[IX_INS]   = snap_evt[0];
  assign snaps[IX_IRQ]   = snap_evt[1];
  assign snaps[IX_NMI]   = snap_evt[2];
  assign snaps[IX_NS]    = snap_ns;
  assign snaps[IX_SPLIT] = snap_split;

  evs_regs #(.AW(16), .DW(8), .BASE(BASE)) i_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wdata(bus_wdata),
    .we(bus_we), .re(bus_re), .snaps(snaps),
    .capture(capture), .rdata(bus_rdata)
  );
endmodule

// File: tb/test_evt_snap_ctr.sv
module test_evt_snap_ctr;
  localparam logic [15:0] BASE = 16'hFFC0;
  localparam int TC = 3, TN = 40, SN = 1000;

  logic clk = 1'b0, rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0, bus_rdata;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic ev_instr = 1'b0, ev_irq = 1'b0, ev_nmi = 1'b0;

  evt_snap_ctr #(.BASE(BASE), .TICK_CYCLES(TC), .TICK_NS(TN), .SEC_NS(SN)) i_evt_snap_ctr (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .ev_instr(ev_instr), .ev_irq(ev_irq),
    .ev_nmi(ev_nmi), .bus_rdata(bus_rdata));

  always #2 clk = ~clk;

  int vectors = 0, errors = 0;
  bit done = 1'b0;
  string tag = "R1";

  // behavioural reference model
  longint unsigned m_cnt[6];
  longint unsigned m_snap[6];
  longint unsigned m_sec, m_sub;
  int m_pc;
  logic [7:0] m_sel, m_rd;

  function automatic logic [7:0] model_read(logic [15:0] a);
    int o;
    longint unsigned v;
    if (a < BASE) return 8'h00;
    o = int'(a - BASE);
    if (o == 1) return m_sel;
    if (o < 2 || o > 9) return 8'h00;
    case (m_sel)
      8'h00: v = m_snap[0];
      8'h01: v = m_snap[1];
      8'h02: v = m_snap[2];
      8'h03: v = m_snap[3];
      8'h80: v = m_snap[4];
      8'h81: v = m_snap[5];
      default: v = 0;
    endcase
    return 8'(v >> (8 * (o - 2)));
  endfunction

  always @(posedge clk) begin
    logic [7:0] nrd;
    if (rst) begin
      for (int i = 0; i < 6; i++) begin m_cnt[i] = 0; m_snap[i] = 0; end
      m_sec = 0; m_sub = 0; m_pc = 0; m_sel = 8'h00; m_rd = 8'h00;
    end else begin
      nrd = bus_re ? model_read(bus_addr) : 8'h00;
      if (bus_we && bus_addr == BASE) begin
        for (int i = 0; i < 5; i++) m_snap[i] = m_cnt[i];
        m_snap[5] = (m_sec << 32) | m_sub;
      end
      if (bus_we && bus_addr == BASE + 16'd1) m_sel = bus_wdata;
      m_cnt[0] += 1;
      if (ev_instr) m_cnt[1] += 1;
      if (ev_irq)   m_cnt[2] += 1;
      if (ev_nmi)   m_cnt[3] += 1;
      if (m_pc == TC - 1) begin
        m_pc = 0;
        m_cnt[4] += TN;
        m_sub += TN;
        if (m_sub >= SN) begin m_sub -= SN; m_sec += 1; end
      end else m_pc++;
      m_rd = nrd;
    end
  end

  always @(negedge clk) begin
    vectors++;
    if (bus_rdata !== m_rd) begin
      errors++;
      $display("FAIL %s bus_rdata actual=%02h expected=%02h at %0t", tag, bus_rdata, m_rd, $time);
    end
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk); bus_re = 1'b0; d = bus_rdata;
  endtask

  task automatic rd64(output longint unsigned v);
    logic [7:0] b;
    v = 0;
    for (int k = 0; k < 8; k++) begin
      rd(BASE + 16'(2 + k), b);
      v = v | (longint'(b) << (8 * k));
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      ev_instr = (i % 3 == 0); ev_irq = (i % 7 == 2); ev_nmi = (i % 11 == 5);
      @(negedge clk);
    end
    ev_instr = 1'b0; ev_irq = 1'b0; ev_nmi = 1'b0;
  endtask

  task automatic chk(input string t, input longint unsigned act, input longint unsigned exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  localparam logic [7:0] CODES [6] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h80, 8'h81};

  initial begin
    longint unsigned v, tot, spl;
    logic [7:0] b;
    tag = "R1"; rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0; @(negedge clk);
    rd(BASE + 16'd1, b); chk("R1 selector reset", b, 0);

    tag = "R2"; run(20);
    for (int c = 0; c < 6; c++) begin
      wr(BASE + 16'd1, CODES[c]); rd64(v); chk("R2 zero before capture", v, 0);
    end

    tag = "R9";
    wr(BASE + 16'd1, 8'h5A); rd(BASE + 16'd1, b); chk("R9 selector readback", b, 8'h5A);
    rd(BASE, b); chk("R9 capture reads zero", b, 0);
    rd(BASE + 16'd1, b); chk("R9 read has no side effect", b, 8'h5A);

    tag = "R5"; run(57); wr(BASE, 8'h33);
    tag = "R3";
    for (int c = 0; c < 6; c++) begin wr(BASE + 16'd1, CODES[c]); rd64(v); end
    tag = "R4";
    wr(BASE + 16'd1, 8'h00);
    for (int k = 9; k >= 2; k--) rd(BASE + 16'(k), b);

    tag = "R6";
    ev_instr = 1'b1; ev_irq = 1'b1; ev_nmi = 1'b1; wr(BASE, 8'h00);
    ev_instr = 1'b0; ev_irq = 1'b0; ev_nmi = 1'b0;
    for (int c = 0; c < 4; c++) begin wr(BASE + 16'd1, CODES[c]); rd64(v); end

    tag = "R7"; run(260); wr(BASE, 8'h01);
    wr(BASE + 16'd1, 8'h80); rd64(tot);
    chk("R7 ns multiple of tick", tot % TN, 0);
    tag = "R8";
    wr(BASE + 16'd1, 8'h81); rd64(spl);
    chk("R8 remainder below second", ((spl & 64'hFFFF_FFFF) < SN) ? 1 : 0, 1);
    chk("R8 split equals total", (spl >> 32) * SN + (spl & 64'hFFFF_FFFF), tot);
    chk("R8 seconds elapsed", ((spl >> 32) > 0) ? 1 : 0, 1);

    tag = "R3";
    wr(BASE + 16'd1, 8'h05); rd64(v); chk("R3 undefined code 05", v, 0);
    wr(BASE + 16'd1, 8'hFF); rd64(v); chk("R3 undefined code FF", v, 0);

    tag = "R11";
    wr(BASE + 16'd1, 8'h01);
    wr(BASE + 16'd2, 8'hAA); wr(BASE + 16'd9, 8'h55);
    wr(BASE + 16'd10, 8'h00); wr(16'h0001, 8'h81); wr(16'h0000, 8'h12);
    rd(BASE + 16'd1, b); chk("R11 selector unchanged", b, 8'h01);
    rd64(v);

    tag = "R10";
    bus_addr = BASE + 16'd1; @(negedge clk);
    chk("R10 no strobe reads zero", bus_rdata, 0);
    rd(BASE + 16'd10, b); chk("R10 outside window", b, 0);
    rd(16'h0001, b); chk("R10 low address", b, 0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule